// File: doc/BRIEF.md
# Annunciator Backplane Driver

This block generates the drive for a static annunciator group: one shared backplane and four frontplane segments. It divides the oscillator clock into a square wave and drives that wave on the backplane. Each frontplane output carries the same wave. A segment that is switched on gets the wave inverted, so it sees the full voltage across it. A segment that is switched off gets the wave in phase, so it sees no net voltage.

The wave has a 50% duty cycle. Each half lasts `half_period + 1` oscillator cycles. A new segment pattern takes effect only at a backplane phase edge, so no output ever carries a short pulse. All outputs are held low in two cases: when the oscillator is disabled, and when the annunciator circuit is disabled.

Top module: `anncr_drive`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `bp_out` and every bit of `fp_out` are 0.
- R2: The first clock edge that sees both `osc_en` and `ann_en` high starts a low half of the backplane. After that, `bp_out` stays low for `half_period + 1` cycles, then high for `half_period + 1` cycles, and repeats.
- R3: A frontplane bit whose latched segment bit is 1 (segment on) equals the inverse of `bp_out` in every running cycle.
- R4: A frontplane bit whose latched segment bit is 0 (segment off) equals `bp_out` in every running cycle.
- R5: Bit k of `seg_on` controls only bit k of `fp_out`, so any mix of on and off segments is driven correctly at once.
- R6: `seg_on` is latched only at a backplane phase edge or at start-up. A change in the middle of a half does not move `fp_out` until the next phase edge.
- R7: From the first clock edge that sees `osc_en` low, all five outputs are 0 and stay 0 while it is low.
- R8: From the first clock edge that sees `ann_en` low while `osc_en` is high, all five outputs are 0 and stay 0 while it is low.
- R9: With `half_period` equal to 0, `bp_out` toggles on every clock edge while running.
- R10: When enabled again after a disable, the wave restarts with a full low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | Oscillator running; when low, all outputs are forced low |
| ann_en | input | 1 | Annunciator circuit enable |
| half_period | input | DIV_W | Terminal count; each half of the wave lasts this value plus one cycle |
| seg_on | input | NSEG | Segment pattern, 1 = on (antiphase), 0 = off (in phase) |
| bp_out | output | 1 | Backplane square wave |
| fp_out | output | NSEG | Frontplane outputs |

## Verification
If the divider count is wrong, a backplane half comes out longer or shorter than `half_period + 1`. This shows at the first phase edge, within one half period. If the segment latch is wrong, a frontplane bit leaves the required phase relation to `bp_out`. This can happen in the same cycle as a phase edge, or in the middle of a half if the latch loads at the wrong time. If the run/idle state is wrong, an output stays high one or more edges after an enable drops, or the first half after a restart is not a full low half.

// File: rtl/anncr_drive.sv
module anncr_drive #(
  parameter int DIV_W = 16,
  parameter int NSEG  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             ann_en,
  input  logic [DIV_W-1:0] half_period,
  input  logic [NSEG-1:0]  seg_on,
  output logic             bp_out,
  output logic [NSEG-1:0]  fp_out
);

  logic             run;
  logic [DIV_W-1:0] cnt;
  logic             bp_q;
  logic [NSEG-1:0]  fp_q;

  wire active = osc_en && ann_en;
  wire at_tc  = cnt >= half_period;

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      run  <= 1'b0;
      cnt  <= '0;
      bp_q <= 1'b0;
      fp_q <= '0;
    end else if (!run) begin
      run  <= 1'b1;
      cnt  <= '0;
      bp_q <= 1'b0;
      fp_q <= seg_on;
    end else if (at_tc) begin
      cnt  <= '0;
      bp_q <= ~bp_q;
      fp_q <= {NSEG{~bp_q}} ^ seg_on;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  assign bp_out = bp_q;
  assign fp_out = fp_q;

endmodule

module anncr_drive_chk #(
  parameter int DIV_W = 16,
  parameter int NSEG  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osc_en,
  input logic             ann_en,
  input logic [DIV_W-1:0] half_period,
  input logic             run,
  input logic [DIV_W-1:0] cnt,
  input logic             bp_out,
  input logic [NSEG-1:0]  fp_out
);

  a_r7_osc_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> (!bp_out && fp_out == '0));

  a_r8_ann_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ann_en |=> (!bp_out && fp_out == '0));

  a_r6_fp_holds_in_half: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $stable(bp_out)) |-> $stable(fp_out));

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $stable(half_period)) |-> (cnt <= half_period));

  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!bp_out && fp_out == '0));

endmodule

bind anncr_drive anncr_drive_chk #(.DIV_W(DIV_W), .NSEG(NSEG)) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .ann_en(ann_en),
  .half_period(half_period), .run(run), .cnt(cnt),
  .bp_out(bp_out), .fp_out(fp_out)
);

// File: tb/anncr_drive_test.sv
`timescale 1ns/1ps
module anncr_drive_test;
  localparam int DIV_W = 16;
  localparam int NSEG  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             osc_en = 1'b0;
  logic             ann_en = 1'b0;
  logic [DIV_W-1:0] half_period = '0;
  logic [NSEG-1:0]  seg_on = '0;
  logic             bp_out;
  logic [NSEG-1:0]  fp_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  anncr_drive #(.DIV_W(DIV_W), .NSEG(NSEG)) uut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .ann_en(ann_en),
    .half_period(half_period), .seg_on(seg_on),
    .bp_out(bp_out), .fp_out(fp_out)
  );

  task automatic check(input string req, input logic [NSEG:0] act, input logic [NSEG:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual bp/fp=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_idle();
    @(negedge clk);
    ann_en = 1'b0;
    osc_en = 1'b1;
    step();
    step();
  endtask

  // Start from idle, then check cycle i against the ideal wave
  task automatic run_wave(input string req, input int tc, input logic [NSEG-1:0] seg, input int n);
    go_idle();
    half_period = tc[DIV_W-1:0];
    seg_on = seg;
    ann_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      logic b;
      step();
      b = ((i / (tc + 1)) % 2) == 1;
      check(req, {bp_out, fp_out}, {b, {NSEG{b}} ^ seg});
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    osc_en = 1'b1;
    ann_en = 1'b1;
    repeat (3) step();
    check("R1 in reset", {bp_out, fp_out}, '0);
    rst_n = 1'b1;
    check("R1 after release", {bp_out, fp_out}, '0);
  endtask

  task automatic t_seg_midhalf();
    go_idle();
    half_period = 16'd3;
    seg_on = 4'b0000;
    ann_en = 1'b1;
    for (int i = 0; i < 12; i++) begin
      logic b;
      logic [NSEG-1:0] s;
      step();
      b = ((i / 4) % 2) == 1;
      s = (i >= 4) ? 4'b1111 : 4'b0000;
      check("R6 latch at phase edge", {bp_out, fp_out}, {b, {NSEG{b}} ^ s});
      if (i == 1) seg_on = 4'b1111;
    end
  endtask

  task automatic t_disable(input bit use_osc);
    go_idle();
    half_period = 16'd1;
    seg_on = 4'b1010;
    ann_en = 1'b1;
    repeat (3) step();
    if (use_osc) osc_en = 1'b0; else ann_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      check(use_osc ? "R7 osc off low" : "R8 ann off low", {bp_out, fp_out}, '0);
    end
    osc_en = 1'b1;
    ann_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      logic b;
      step();
      b = ((i / 2) % 2) == 1;
      check("R10 restart low half", {bp_out, fp_out}, {b, {NSEG{b}} ^ 4'b1010});
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    run_wave("R2 R3 R4 R5 tc3 mix", 3, 4'b0101, 24);
    run_wave("R3 all on tc2", 2, 4'b1111, 15);
    run_wave("R4 all off tc5", 5, 4'b0000, 24);
    run_wave("R5 single seg", 4, 4'b1000, 20);
    run_wave("R9 tc0 toggle", 0, 4'b0110, 8);
    t_seg_midhalf();
    t_disable(1'b1);
    t_disable(1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule